// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the target side of a three-wire serial link. The link has an active-high select, a serial clock and one data line; here the data line is split into an input, an output and an output enable for the pad. All three incoming lines are brought into the system clock domain and their edges are detected there. Each framed transfer opens with a command byte. The command picks a read or a write, picks the register bank or the scratch RAM, and gives an index. Data bytes then move between the link and either a small register file or a 31-byte scratch RAM.

A transfer moves one byte, or it is a burst. A clock burst covers the eight clock-group registers: seven time fields and then the control byte. A RAM burst walks the scratch RAM from location 0. Time registers are loaded only when a transfer ends cleanly. A write-protect bit in the control register locks every location except the control register.

Top module: `tws_reg_slave`

## Requirements
- R1: Bits are sampled on serial-clock rising edges, least significant bit first. In the command byte, bit 0 = 1 means read and 0 means write, bits 5..1 are the index, and bit 6 = 1 selects the RAM while 0 selects the registers. Register indices are 0..6 for the time fields, 7 for control, 9 for century, 10 for alarm configuration and 12..18 for the thresholds. RAM indices are 0..30.
- R2: A command byte whose bit 7 is 0 voids the whole transfer. Nothing is written and the data line is never driven.
- R3: In a read, the output enable rises after the eighth falling edge of the serial clock, and each bit is presented after a falling edge, least significant bit first. The line is released on every rising edge, and it stays released while select is low.
- R4: A single-byte read that keeps clocking past its byte presents the same location again.
- R5: Register index 31 (commands 0xBF read and 0xBE write) is the clock burst. A clock-burst read returns register indices 0..7 in that order and then leaves the line released.
- R6: A clock-burst write is held in a buffer. It is applied when select falls, and only if all eight bytes arrived. A shorter burst changes nothing.
- R7: RAM index 31 (commands 0xFF read and 0xFE write) is the RAM burst. In a burst write, each complete byte is stored at once in consecutive locations starting from 0. A byte cut short by select falling is dropped.
- R8: A RAM-burst read returns all 31 locations starting at 0 and then leaves the line released.
- R9: A single-byte write uses only its first data byte. Any further clocks are ignored.
- R10: A single write to a time field (indices 0..6) is held until select falls. If select falls before the data byte is complete, the register keeps its value.
- R11: While control bit 7 (write protect) is 1, no register or RAM location takes a write, with one exception: the control register. It can still be written by a single write, and the eighth byte of a complete clock burst also reaches it.
- R12: Control bits 6..0 always read as 0, whatever was written to them.
- R13: Indices 8 and 11 (commands 0x90 and 0x96), and indices 19..30, cannot be written and read as 0.
- R14: After reset the register values are: time fields 00,00,00,01,01,01,70 (hex), control 00, century 19, alarm configuration 00, thresholds 7F,7F,BF,3F,1F,07,FF. The data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial lines are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Transfer select, active high |
| sck_i | input | 1 | Serial clock from the master |
| sd_i | input | 1 | Serial data from the master |
| sd_o | output | 1 | Serial data towards the master |
| sd_oe | output | 1 | Output enable for the data pad |

## Verification
The bench aims at the cases where a transfer is cut short. These are a clock burst stopped after five bytes, a single write to a time field dropped in the middle of its data byte, and a RAM burst that ends on a partial byte. A design that committed too early would show the new time fields, or a stray RAM byte, when the bench reads them back. The bench also tests the command gates: a bit-7-clear command, and writes made while the write-protect bit is set. A slave that ignored either gate would return changed values, or would drive the line when it must stay silent. Each read bit is checked against its drive window. Reads that clock past their end also confirm two more faults would be caught: a drive that outlives a burst, and a single read that moves on to the next address instead of repeating.

// File: rtl/tws_pkg.sv
package tws_pkg;
   localparam int BYTE_W        = 8;
   localparam int IDX_W         = 5;
   localparam int TIME_CNT      = 7;
   localparam int CLK_BURST_LEN = 8;
   localparam int REG_CNT       = 19;
   localparam logic [IDX_W-1:0] IDX_BURST = 5'd31;
   localparam logic [IDX_W-1:0] IDX_CTRL  = 5'd7;

   typedef enum logic [1:0] {PH_CMD, PH_WRITE, PH_READ, PH_DONE} phase_t;

   typedef struct packed {
      logic             valid;
      logic             ram;
      logic [IDX_W-1:0] idx;
      logic             rd;
   } cmd_t;

   function automatic logic [BYTE_W-1:0] reg_init(input int i);
      case (i)
         3, 4, 5: return 8'h01;
         6:       return 8'h70;
         9:       return 8'h19;
         12, 13:  return 8'h7F;
         14:      return 8'hBF;
         15:      return 8'h3F;
         16:      return 8'h1F;
         17:      return 8'h07;
         18:      return 8'hFF;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic reg_reserved(input int i);
      return (i == 8) || (i == 11);
   endfunction

   function automatic logic reg_direct(input int i);
      return (i == 9) || (i == 10) || ((i >= 12) && (i < REG_CNT));
   endfunction
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tws_line_sync: STAGES must be at least 2");
      end
      for (genvar l = 0; l < LINES; l++) begin : g_line
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], din[l]};
         end
         assign dout[l] = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tws_frame.sv
module tws_frame
   import tws_pkg::*;
#(
   parameter int RAM_DEPTH = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sck_s,
   input  logic              sd_s,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              rd_ram,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              wr_en,
   output logic              wr_ram,
   output logic              wr_burst,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic              commit,
   output logic              commit_full,
   output logic              sd_o,
   output logic              sd_oe
);
   localparam int SPAN  = (RAM_DEPTH > CLK_BURST_LEN) ? RAM_DEPTH : CLK_BURST_LEN;
   localparam int CNT_W = $clog2(SPAN + 1);

   generate
      if (RAM_DEPTH < 1 || RAM_DEPTH > 31) begin : g_bad_depth
         $error("tws_frame: RAM_DEPTH must lie in 1..31");
      end
   endgenerate

   phase_t            phase;
   logic [2:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  bcnt;
   logic              cmd_ram;
   logic [IDX_W-1:0]  cmd_idx;
   logic              full_q;
   logic              cs_prev, sck_prev;

   logic              sck_rise, sck_fall, cs_fall;
   logic [BYTE_W-1:0] nxt;
   cmd_t              dec;
   logic              is_burst;
   logic [CNT_W-1:0]  lim_m1;

   assign sck_rise = sck_s & ~sck_prev;
   assign sck_fall = ~sck_s & sck_prev;
   assign cs_fall  = ~cs_s & cs_prev;
   assign nxt      = {sd_s, shreg[BYTE_W-1:1]};
   assign dec      = cmd_t'(nxt);
   assign is_burst = (cmd_idx == IDX_BURST);
   assign lim_m1   = cmd_ram ? CNT_W'(RAM_DEPTH - 1) : CNT_W'(CLK_BURST_LEN - 1);
   assign rd_ram   = cmd_ram;
   assign rd_idx   = is_burst ? IDX_W'(bcnt) : cmd_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_CMD;
         bitcnt      <= '0;
         shreg       <= '0;
         bcnt        <= '0;
         cmd_ram     <= 1'b0;
         cmd_idx     <= '0;
         full_q      <= 1'b0;
         cs_prev     <= 1'b0;
         sck_prev    <= 1'b0;
         wr_en       <= 1'b0;
         wr_ram      <= 1'b0;
         wr_burst    <= 1'b0;
         wr_idx      <= '0;
         wr_data     <= '0;
         commit      <= 1'b0;
         commit_full <= 1'b0;
         sd_o        <= 1'b0;
         sd_oe       <= 1'b0;
      end else begin
         cs_prev  <= cs_s;
         sck_prev <= sck_s;
         wr_en    <= 1'b0;
         commit   <= 1'b0;
         if (!cs_s) begin
            phase  <= PH_CMD;
            bitcnt <= '0;
            bcnt   <= '0;
            sd_oe  <= 1'b0;
            if (cs_fall) begin
               commit      <= 1'b1;
               commit_full <= full_q;
            end
            full_q <= 1'b0;
         end else if (sck_rise) begin
            sd_oe  <= 1'b0;
            shreg  <= nxt;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
               unique case (phase)
                  PH_CMD: begin
                     cmd_ram <= dec.ram;
                     cmd_idx <= dec.idx;
                     if (!dec.valid)  phase <= PH_DONE;
                     else if (dec.rd) phase <= PH_READ;
                     else             phase <= PH_WRITE;
                  end
                  PH_WRITE: begin
                     wr_en    <= 1'b1;
                     wr_data  <= nxt;
                     wr_ram   <= cmd_ram;
                     wr_burst <= is_burst & ~cmd_ram;
                     wr_idx   <= rd_idx;
                     if (!is_burst) begin
                        phase <= PH_DONE;
                     end else begin
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == lim_m1) begin
                           phase <= PH_DONE;
                           if (!cmd_ram) full_q <= 1'b1;
                        end
                     end
                  end
                  PH_READ: begin
                     if (is_burst) begin
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == lim_m1) phase <= PH_DONE;
                     end
                  end
                  default: ;
               endcase
            end
         end else if (sck_fall && phase == PH_READ) begin
            sd_oe <= 1'b1;
            sd_o  <= rd_data[bitcnt];
         end
      end
   end

   p_release_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !sd_oe);
   p_release_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && sck_rise) |=> !sd_oe);
   p_drive_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_oe) |-> $past(sck_fall));
   p_commit_on_cs_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !cs_s);
endmodule

// File: rtl/tws_regfile.sv
module tws_regfile
   import tws_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ram,
   input  logic              wr_burst,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              commit,
   input  logic              commit_full,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BYTE_W-1:0] rd_data,
   output logic              wp
);
   logic [REG_CNT-1:0][BYTE_W-1:0]       regs;
   logic [CLK_BURST_LEN-1:0][BYTE_W-1:0] bbuf;
   logic                                 stg_valid;
   logic [2:0]                           stg_idx;
   logic [BYTE_W-1:0]                    stg_data;

   assign wp = regs[IDX_CTRL][BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_CNT; i++) regs[i] <= reg_init(i);
         bbuf      <= '0;
         stg_valid <= 1'b0;
         stg_idx   <= '0;
         stg_data  <= '0;
      end else begin
         if (wr_en && !wr_ram) begin
            if (wr_burst) begin
               bbuf[wr_idx[2:0]] <= wr_data;
            end else if (wr_idx == IDX_CTRL) begin
               regs[IDX_CTRL] <= {wr_data[BYTE_W-1], {(BYTE_W-1){1'b0}}};
            end else if (!wp) begin
               if (wr_idx < IDX_W'(TIME_CNT)) begin
                  stg_valid <= 1'b1;
                  stg_idx   <= wr_idx[2:0];
                  stg_data  <= wr_data;
               end
               for (int i = TIME_CNT + 1; i < REG_CNT; i++)
                  if (wr_idx == IDX_W'(i) && reg_direct(i)) regs[i] <= wr_data;
            end
         end
         if (commit) begin
            stg_valid <= 1'b0;
            if (stg_valid) regs[stg_idx] <= stg_data;
            if (commit_full) begin
               if (!wp)
                  for (int i = 0; i < TIME_CNT; i++) regs[i] <= bbuf[i];
               regs[IDX_CTRL] <= {bbuf[CLK_BURST_LEN-1][BYTE_W-1], {(BYTE_W-1){1'b0}}};
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < REG_CNT; i++)
         if (rd_idx == IDX_W'(i) && !reg_reserved(i)) rd_data = regs[i];
   end

   p_time_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(regs[TIME_CNT-1:0]));
   p_wp_locks_regs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wp |=> $stable(regs[REG_CNT-1:IDX_CTRL+1]));
   p_short_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !commit_full && !stg_valid) |=> $stable(regs[TIME_CNT-1:0]));
endmodule

// File: rtl/tws_ram.sv
module tws_ram
   import tws_pkg::*;
#(
   parameter int DEPTH = 31,
   parameter bit CLEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              wp,
   input  logic [IDX_W-1:0]  widx,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [BYTE_W-1:0] rdata
);
   logic [DEPTH-1:0][BYTE_W-1:0] mem;
   logic                         write_ok;

   assign write_ok = we & ~wp;

   generate
      if (CLEAR) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem <= '0;
            else if (write_ok)
               for (int i = 0; i < DEPTH; i++)
                  if (widx == IDX_W'(i)) mem[i] <= wdata;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (write_ok)
               for (int i = 0; i < DEPTH; i++)
                  if (widx == IDX_W'(i)) mem[i] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++)
         if (ridx == IDX_W'(i)) rdata = mem[i];
   end

   p_ram_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wp |=> $stable(mem));
   p_ram_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(widx) >= DEPTH) |=> $stable(mem));
endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave
   import tws_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RAM_DEPTH   = 31,
   parameter bit RAM_CLEAR   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic sd_i,
   output logic sd_o,
   output logic sd_oe
);
   logic [2:0]        lines_s;
   logic              rd_ram, wr_en, wr_ram, wr_burst, commit, commit_full, wp;
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic [BYTE_W-1:0] wr_data, rd_data, reg_q, ram_q;

   tws_line_sync #(.STAGES(SYNC_STAGES), .LINES(3)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({sd_i, sck_i, cs_i}),
      .dout (lines_s)
   );

   tws_frame #(.RAM_DEPTH(RAM_DEPTH)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (lines_s[0]),
      .sck_s      (lines_s[1]),
      .sd_s       (lines_s[2]),
      .rd_data    (rd_data),
      .rd_ram     (rd_ram),
      .rd_idx     (rd_idx),
      .wr_en      (wr_en),
      .wr_ram     (wr_ram),
      .wr_burst   (wr_burst),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .commit     (commit),
      .commit_full(commit_full),
      .sd_o       (sd_o),
      .sd_oe      (sd_oe)
   );

   tws_regfile u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_ram     (wr_ram),
      .wr_burst   (wr_burst),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .commit     (commit),
      .commit_full(commit_full),
      .rd_idx     (rd_idx),
      .rd_data    (reg_q),
      .wp         (wp)
   );

   tws_ram #(.DEPTH(RAM_DEPTH), .CLEAR(RAM_CLEAR)) u_ram (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en & wr_ram),
      .wp   (wp),
      .widx (wr_idx),
      .wdata(wr_data),
      .ridx (rd_idx),
      .rdata(ram_q)
   );

   assign rd_data = rd_ram ? ram_q : reg_q;
endmodule

// File: tb/tws_reg_slave_test.sv
module tws_reg_slave_test;
   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
   logic sdo, oe;

   tws_reg_slave uut (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sd_i(sdi),
      .sd_o(sdo), .sd_oe(oe)
   );

   always #4 clk = ~clk;

   localparam int HALF = 64;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } item_t;

   item_t      exp_q[$];
   logic [7:0] got_q[$];
   int n_chk = 0, n_bad = 0, oe_cnt = 0;
   logic [7:0] ram_m [31];

   always @(posedge clk) if (oe) oe_cnt <= oe_cnt + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   initial forever begin
      item_t      e;
      logic [7:0] g;
      wait (got_q.size() > 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      check(g == e.val, e.tag, g, e.val);
   end

   task automatic expect_byte(input logic [7:0] v, input string tag);
      item_t it;
      it.val = v;
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         sdi = b[i];
         #HALF sck = 1'b1;
         #HALF sck = 1'b0;
      end
   endtask

   task automatic open_xfer();
      cs = 1'b1;
      #HALF;
   endtask

   task automatic close_xfer();
      #HALF;
      cs  = 1'b0;
      sdi = 1'b0;
      #(4 * HALF);
      check(oe == 1'b0, "R3 line released while select low", oe, 0);
   endtask

   task automatic recv_byte();
      logic [7:0] b;
      int bad = 0;
      sdi = 1'b0;
      for (int i = 0; i < 8; i++) begin
         #(HALF - 8);
         if (!oe) bad++;
         b[i] = sdo;
         #8 sck = 1'b1;
         #(HALF - 8);
         if (oe) bad++;
         #8 sck = 1'b0;
      end
      got_q.push_back(b);
      check(bad == 0, "R3 drive window per bit", bad, 0);
   endtask

   task automatic silent_byte(input string tag);
      int snap = oe_cnt;
      send_bits(8'h00, 8);
      check(oe_cnt == snap, tag, oe_cnt - snap, 0);
   endtask

   task automatic wr_bytes(input logic [7:0] cmd, input logic [63:0] d, input int n);
      int snap = oe_cnt;
      open_xfer();
      send_bits(cmd, 8);
      for (int i = 0; i < n; i++) send_bits(d[8*i +: 8], 8);
      close_xfer();
      check(oe_cnt == snap, "R3 no drive during write", oe_cnt - snap, 0);
   endtask

   task automatic rd_n(input logic [7:0] cmd, input int n, input bit extra, input string tag);
      open_xfer();
      send_bits(cmd, 8);
      for (int i = 0; i < n; i++) recv_byte();
      if (extra) silent_byte(tag);
      close_xfer();
   endtask

   task automatic rd1(input logic [7:0] cmd, input logic [7:0] v, input string tag);
      expect_byte(v, tag);
      rd_n(cmd, 1, 1'b0, tag);
   endtask

   initial begin
      #1_200_000;
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] clk_exp [8];
      for (int i = 0; i < 31; i++) ram_m[i] = 8'h00;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check(oe == 1'b0, "R14 line released after reset", oe, 0);

      // R14 reset contents through single reads (R1 index decode)
      rd1(8'h81, 8'h00, "R14 seconds reset");
      rd1(8'h8D, 8'h70, "R14 year reset");
      rd1(8'h93, 8'h19, "R14 century reset");
      rd1(8'h9D, 8'hBF, "R14 hour threshold reset");
      rd1(8'hA5, 8'hFF, "R14 year threshold reset");

      // R5 clock burst read order, then released
      clk_exp = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h70, 8'h00};
      for (int i = 0; i < 8; i++) expect_byte(clk_exp[i], "R5 clock burst read order");
      rd_n(8'hBF, 8, 1'b1, "R5 released after clock burst");

      // R6 full clock burst write
      wr_bytes(8'hBE, 64'h00_02_04_07_04_22_11_31, 8);
      clk_exp = '{8'h31, 8'h11, 8'h22, 8'h04, 8'h07, 8'h04, 8'h02, 8'h00};
      for (int i = 0; i < 8; i++) expect_byte(clk_exp[i], "R6 full burst applied");
      rd_n(8'hBF, 8, 1'b0, "R6");

      // R6 short clock burst changes nothing
      wr_bytes(8'hBE, 64'h00_00_00_55_55_55_55_55, 5);
      for (int i = 0; i < 8; i++) expect_byte(clk_exp[i], "R6 short burst ignored");
      rd_n(8'hBF, 8, 1'b0, "R6");

      // R9 single write, extra byte ignored
      wr_bytes(8'h82, 64'hAA45, 2);
      rd1(8'h83, 8'h45, "R9 extra clocks ignored");

      // R10 aborted single write to a time field
      open_xfer();
      send_bits(8'h82, 8);
      send_bits(8'h0F, 4);
      close_xfer();
      rd1(8'h83, 8'h45, "R10 aborted time write");

      // R4 single read repeats
      expect_byte(8'h45, "R4 first byte");
      expect_byte(8'h45, "R4 repeated byte");
      rd_n(8'h83, 2, 1'b0, "R4");

      // R1 RAM single write and read
      wr_bytes(8'hC4, 64'h5A, 1);
      ram_m[2] = 8'h5A;
      rd1(8'hC5, 8'h5A, "R1 RAM index 2");

      // R2 bit 7 clear: no write, no drive
      wr_bytes(8'h02, 64'h99, 1);
      rd1(8'h83, 8'h45, "R2 register untouched");
      wr_bytes(8'h44, 64'h77, 1);
      rd1(8'hC5, 8'h5A, "R2 RAM untouched");
      open_xfer();
      send_bits(8'h03, 8);
      silent_byte("R2 read with bit 7 clear stays silent");
      close_xfer();

      // R7 RAM burst write with a dropped partial byte
      open_xfer();
      send_bits(8'hFE, 8);
      send_bits(8'h11, 8);
      send_bits(8'h22, 8);
      send_bits(8'h33, 8);
      send_bits(8'hFF, 4);
      close_xfer();
      ram_m[0] = 8'h11; ram_m[1] = 8'h22; ram_m[2] = 8'h33;
      rd1(8'hC1, 8'h11, "R7 RAM burst byte 0");
      rd1(8'hC3, 8'h22, "R7 RAM burst byte 1");
      rd1(8'hC5, 8'h33, "R7 RAM burst byte 2");
      rd1(8'hC7, 8'h00, "R7 partial byte dropped");

      // R8 RAM burst read
      for (int i = 0; i < 31; i++) expect_byte(ram_m[i], "R8 RAM burst read");
      rd_n(8'hFF, 31, 1'b1, "R8 released after RAM burst");

      // R12 control low bits
      wr_bytes(8'h8E, 64'h7F, 1);
      rd1(8'h8F, 8'h00, "R12 control low bits read zero");

      // R11 write protect
      wr_bytes(8'h8E, 64'hFF, 1);
      rd1(8'h8F, 8'h80, "R12 control reads protect bit only");
      wr_bytes(8'h82, 64'h12, 1);
      rd1(8'h83, 8'h45, "R11 time write blocked");
      wr_bytes(8'hC4, 64'hEE, 1);
      rd1(8'hC5, 8'h33, "R11 RAM write blocked");
      wr_bytes(8'h92, 64'h20, 1);
      rd1(8'h93, 8'h19, "R11 century write blocked");
      wr_bytes(8'hBE, 64'h00_09_09_09_09_09_09_09, 8);
      clk_exp = '{8'h31, 8'h45, 8'h22, 8'h04, 8'h07, 8'h04, 8'h02, 8'h00};
      for (int i = 0; i < 8; i++) expect_byte(clk_exp[i], "R11 burst reaches control only");
      rd_n(8'hBF, 8, 1'b0, "R11");
      wr_bytes(8'h92, 64'h20, 1);
      rd1(8'h93, 8'h20, "R11 write accepted after unlock");

      // R13 reserved and unused indices
      wr_bytes(8'h90, 64'h55, 1);
      rd1(8'h91, 8'h00, "R13 index 8 reserved");
      wr_bytes(8'h96, 64'h66, 1);
      rd1(8'h97, 8'h00, "R13 index 11 reserved");
      wr_bytes(8'hA6, 64'h5C, 1);
      rd1(8'hA7, 8'h00, "R13 index 19 unused");

      wait (got_q.size() == 0);
      #100;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule